// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of a small serial EEPROM with sixty-four 16-bit words. It is intended as a device stand-in: a host-side controller drives its chip-select, serial clock and serial data-in lines, and reads the device's data-out line. All three inputs are synchronous to a fast system clock, and the model detects serial-clock rising edges by oversampling them.

A frame begins with a 1 bit. Zero bits before it are ignored. The 1 bit is followed by a 2-bit opcode and a 6-bit address, each sent MSB first. A read returns a word. A write or a write-all is followed by 16 data bits. Erase commands need no data. One opcode value selects four housekeeping commands, and the top two address bits choose among them. Any command that changes storage takes effect only while a write-enable latch is set. It runs when chip select falls after a complete frame. While the device programs, the data-out line shows its busy or ready state.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every word reads 16'hFFFF, the write-enable latch is clear and `dout` is 0.
- R2: A frame starts on the first serial-clock rising edge with `di`=1 while chip select is high. Any 0 bits before it are skipped. The next 8 bits are opcode[1:0] and then address[5:0], MSB first.
- R3: Opcode 2'b10 (read) drives `dout`=0 after the last address bit. The next 16 serial-clock rising edges then present D15 down to D0.
- R4: Opcode 2'b01 (write) takes 16 data bits, D15 first. When chip select falls, the word is stored at the address.
- R5: Opcode 2'b11 (erase) sets the addressed word to 16'hFFFF and leaves every other word unchanged.
- R6: Opcode 2'b00 with address[5:4]=2'b10 sets every word to 16'hFFFF.
- R7: Opcode 2'b00 with address[5:4]=2'b01 takes 16 data bits and writes them into every word.
- R8: Opcode 2'b00 with address[5:4]=2'b11 sets the write-enable latch, and address[5:4]=2'b00 clears it. Address[3:0] is ignored for both. While the latch is clear, write, erase, erase-all and write-all change nothing.
- R9: After a programming command, chip select falls and then rises again. `dout` then reads 0 for BUSY_CYC system clocks counted from the fall, and 1 afterwards. Frames sent while busy are ignored.
- R10: If chip select drops before a frame is complete, the frame is aborted and storage is unchanged.
- R11: `dout` is 0 whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; data is taken on its rising edge |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out: read data or the busy/ready status |

## Verification
The assertions assume that `cs`, `sk` and `di` change only between system-clock edges. They also assume that each serial-clock level lasts at least one system clock, so every rising edge is seen exactly once. The stimulus meets both assumptions: it changes inputs only on falling system-clock edges and holds each serial-clock phase for four system clocks. It also holds `sk` low whenever chip select changes, so a select edge never falls on the same cycle as a data bit.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam logic [1:0] OP_SYS   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] SYS_LOCK   = 2'b00;
    localparam logic [1:0] SYS_FILL   = 2'b01;
    localparam logic [1:0] SYS_CLEAR  = 2'b10;
    localparam logic [1:0] SYS_UNLOCK = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_DATA,
        S_READ,
        S_DONE
    } mw_state_e;

    typedef enum logic [2:0] {
        P_NONE,
        P_WORD,
        P_WIPE,
        P_WIPE_ALL,
        P_FILL_ALL
    } mw_prog_e;

endpackage

// File: rtl/mw_edge.sv
module mw_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = level & ~prev_q;
        end else begin : g_fall
            assign pulse = ~level & prev_q;
        end
    endgenerate
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] words_d, words_q;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_word
            always_comb begin
                words_d[gi] = words_q[gi];
                if (we_all || (we_one && waddr == ADDR_W'(gi)))
                    words_d[gi] = wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) words_q <= '1;
        else        words_q <= words_d;
    end

    assign rdata = words_q[raddr];

    AST_ARRAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_one || we_all) |=> $stable(words_q)); // R10

    AST_ALL_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        we_all |=> (words_q[0] == words_q[DEPTH-1])); // R7
endmodule

// File: rtl/mw_cmd.sv
module mw_cmd
    import mw_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int BUSY_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              di,
    input  logic              sk_rise,
    input  logic              cs_fall,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic              we_one,
    output logic              we_all,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata,
    output logic              dout
);
    localparam int HDR_W = 2 + ADDR_W;
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int BW    = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        mw_state_e         st;
        mw_prog_e          pend;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sr;
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic              wen;
        logic              stat;
        logic              rd;
        logic [BW-1:0]     bcnt;
    } regs_t;

    regs_t d, q;
    logic [HDR_W-1:0] hdr;
    logic             busy;

    always_comb begin
        d      = q;
        we_one = 1'b0;
        we_all = 1'b0;
        waddr  = q.addr;
        wdata  = q.sr;
        hdr    = {q.sr[HDR_W-2:0], di};
        raddr  = hdr[ADDR_W-1:0];
        busy   = (q.bcnt != '0);

        if (busy) d.bcnt = q.bcnt - 1'b1;

        if (!cs) begin
            d.st   = S_IDLE;
            d.pend = P_NONE;
            d.cnt  = '0;
            d.rd   = 1'b0;
            if (cs_fall && q.pend != P_NONE) begin
                case (q.pend)
                    P_WORD:     we_one = 1'b1;
                    P_WIPE:     begin we_one = 1'b1; wdata = '1; end
                    P_WIPE_ALL: begin we_all = 1'b1; wdata = '1; end
                    P_FILL_ALL: we_all = 1'b1;
                    default:    ;
                endcase
                d.bcnt = BW'(BUSY_CYC);
                d.stat = 1'b1;
            end
        end else if (sk_rise) begin
            case (q.st)
                S_IDLE: begin
                    if (di && !busy) begin
                        d.st   = S_HDR;
                        d.cnt  = '0;
                        d.stat = 1'b0;
                    end
                end
                S_HDR: begin
                    d.sr  = {q.sr[DATA_W-2:0], di};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(HDR_W - 1)) begin
                        d.cnt  = '0;
                        d.addr = hdr[ADDR_W-1:0];
                        d.op   = hdr[HDR_W-1 -: 2];
                        case (hdr[HDR_W-1 -: 2])
                            OP_READ: begin
                                d.st = S_READ;
                                d.sr = rdata;
                                d.rd = 1'b0;
                            end
                            OP_WRITE: d.st = S_DATA;
                            OP_ERASE: begin
                                d.st   = S_DONE;
                                d.pend = q.wen ? P_WIPE : P_NONE;
                            end
                            default: begin
                                d.st = S_DONE;
                                case (hdr[ADDR_W-1 -: 2])
                                    SYS_UNLOCK: d.wen = 1'b1;
                                    SYS_LOCK:   d.wen = 1'b0;
                                    SYS_CLEAR:  d.pend = q.wen ? P_WIPE_ALL : P_NONE;
                                    default:    d.st = S_DATA;
                                endcase
                            end
                        endcase
                    end
                end
                S_DATA: begin
                    d.sr  = {q.sr[DATA_W-2:0], di};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(DATA_W - 1)) begin
                        d.st = S_DONE;
                        if (!q.wen)               d.pend = P_NONE;
                        else if (q.op == OP_WRITE) d.pend = P_WORD;
                        else                      d.pend = P_FILL_ALL;
                    end
                end
                S_READ: begin
                    if (q.cnt != CNT_W'(DATA_W)) begin
                        d.rd  = q.sr[DATA_W-1];
                        d.sr  = {q.sr[DATA_W-2:0], 1'b0};
                        d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.st = S_DONE;
                        d.rd = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout = cs & ((q.st == S_READ && q.rd) ||
                        (q.st == S_IDLE && q.stat && q.bcnt == '0));

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (q.st == S_IDLE)); // R10

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !dout); // R11

    AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (we_one || we_all) |-> q.wen); // R8

    AST_BUSY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we_one || we_all) |=> (q.bcnt == BW'(BUSY_CYC))); // R9

    AST_READ_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_READ && q.cnt == '0) |-> !dout); // R3
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int BUSY_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout
);
    logic              sk_rise, cs_fall;
    logic              we_one, we_all;
    logic [ADDR_W-1:0] raddr, waddr;
    logic [DATA_W-1:0] rdata, wdata;

    mw_edge #(.RISING(1'b1)) u_sk_edge (
        .clk(clk), .rst_n(rst_n), .level(sk), .pulse(sk_rise));

    mw_edge #(.RISING(1'b0)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .level(cs), .pulse(cs_fall));

    mw_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cs(cs), .di(di),
        .sk_rise(sk_rise), .cs_fall(cs_fall), .rdata(rdata),
        .raddr(raddr), .we_one(we_one), .we_all(we_all),
        .waddr(waddr), .wdata(wdata), .dout(dout));

    mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we_one(we_one), .we_all(we_all),
        .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata));
endmodule

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
    localparam int BUSY = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;
    logic [15:0] rd_w;
    logic        rd_dummy, rdy_first;
    int          rdy_n;

    always #10 clk = ~clk;

    mw_eeprom #(.ADDR_W(6), .DATA_W(16), .BUSY_CYC(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // {addr[5:0], data[15:0]}
    localparam logic [21:0] VEC [6] = '{
        {6'd0,  16'h1234}, {6'd63, 16'hAAAA}, {6'd17, 16'h5555},
        {6'd32, 16'h0000}, {6'd9,  16'h8001}, {6'd44, 16'hC3A5}};

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bit_(logic b);
        di = b; sk = 1'b0;
        repeat (4) @(negedge clk);
        sk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic sel();
        cs = 1'b1; sk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic desel();
        cs = 1'b0; sk = 1'b0; di = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic hdr(logic [1:0] op, logic [5:0] a);
        bit_(1'b1);
        for (int i = 1; i >= 0; i--) bit_(op[i]);
        for (int i = 5; i >= 0; i--) bit_(a[i]);
    endtask

    task automatic rd(logic [5:0] a, int lz);
        sel();
        for (int i = 0; i < lz; i++) bit_(1'b0);
        hdr(2'b10, a);
        rd_dummy = dout;
        for (int i = 0; i < 16; i++) begin
            bit_(1'b0);
            rd_w = {rd_w[14:0], dout};
        end
        desel();
    endtask

    task automatic wait_ready();
        cs = 1'b1; sk = 1'b0;
        @(negedge clk);
        rdy_first = dout;
        rdy_n = 0;
        while (dout == 1'b0 && rdy_n < BUSY + 50) begin
            @(negedge clk);
            rdy_n++;
        end
        desel();
    endtask

    task automatic send(logic [1:0] op, logic [5:0] a, logic [15:0] data, bit has_data);
        sel();
        hdr(op, a);
        if (has_data)
            for (int i = 15; i >= 0; i--) bit_(data[i]);
        desel();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 dout in reset", 16'(dout), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        rd(6'd0, 0);
        check("R1 word 0 after reset", rd_w, 16'hFFFF);
        check("R3 dummy bit", 16'(rd_dummy), 16'h0);
        rd(6'd63, 0);
        check("R1 word 63 after reset", rd_w, 16'hFFFF);

        // write with latch still clear: ignored
        send(2'b01, 6'd5, 16'h1234, 1'b1);
        rd(6'd5, 0);
        check("R8 write without enable", rd_w, 16'hFFFF);

        // enable with nonzero don't-care bits
        send(2'b00, 6'b110101, 16'h0, 1'b0);

        for (int i = 0; i < 6; i++) begin
            send(2'b01, VEC[i][21:16], VEC[i][15:0], 1'b1);
            wait_ready();
            check("R9 busy first sample", 16'(rdy_first), 16'h0);
            checks++;
            if (rdy_n < BUSY - 6 || rdy_n > BUSY) begin
                fails++;
                $display("FAIL R9 busy length actual=%0d expected=%0d", rdy_n, BUSY - 3);
            end
        end
        for (int i = 0; i < 6; i++) begin
            rd(VEC[i][21:16], 0);
            check("R4 R3 readback", rd_w, VEC[i][15:0]);
        end

        rd(VEC[0][21:16], 3);
        check("R2 leading zeros", rd_w, VEC[0][15:0]);

        send(2'b11, VEC[1][21:16], 16'h0, 1'b0);
        wait_ready();
        rd(VEC[1][21:16], 0);
        check("R5 erased word", rd_w, 16'hFFFF);
        rd(VEC[2][21:16], 0);
        check("R5 neighbour kept", rd_w, VEC[2][15:0]);

        // abort: drop select after 8 data bits
        sel();
        hdr(2'b01, VEC[2][21:16]);
        for (int i = 0; i < 8; i++) bit_(1'b0);
        desel();
        rd(VEC[2][21:16], 0);
        check("R10 aborted write", rd_w, VEC[2][15:0]);

        // frame sent during busy is ignored
        send(2'b01, 6'd20, 16'h0F0F, 1'b1);
        send(2'b01, 6'd21, 16'h1111, 1'b1);
        wait_ready();
        rd(6'd21, 0);
        check("R9 frame while busy", rd_w, 16'hFFFF);
        rd(6'd20, 0);
        check("R4 word 20", rd_w, 16'h0F0F);

        send(2'b00, 6'b011010, 16'h3C3C, 1'b1);
        wait_ready();
        rd(6'd0, 0);
        check("R7 fill word 0", rd_w, 16'h3C3C);
        rd(6'd33, 0);
        check("R7 fill word 33", rd_w, 16'h3C3C);
        rd(6'd63, 0);
        check("R7 fill word 63", rd_w, 16'h3C3C);

        send(2'b00, 6'b100110, 16'h0, 1'b0);
        wait_ready();
        rd(6'd0, 0);
        check("R6 clear word 0", rd_w, 16'hFFFF);
        rd(6'd63, 0);
        check("R6 clear word 63", rd_w, 16'hFFFF);

        // first read bit high, then deselect
        sel();
        hdr(2'b10, 6'd2);
        bit_(1'b0);
        check("R3 first data bit", 16'(dout), 16'h1);
        cs = 1'b0;
        @(negedge clk);
        check("R11 dout low when deselected", 16'(dout), 16'h0);
        desel();

        // disable with nonzero don't-care bits
        send(2'b00, 6'b001011, 16'h0, 1'b0);
        send(2'b01, 6'd7, 16'h7777, 1'b1);
        rd(6'd7, 0);
        check("R8 write after disable", rd_w, 16'hFFFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule